// File: doc/BRIEF.md
# Frame Schedule Walker

This block runs the periodic part of a host-side bus controller. On every 1 ms frame tick, and only while the run input is high, it reads the frame-list entry for the current frame. It then follows link pointers through queue heads and transfer descriptors in system memory. Each descriptor it reaches is handed to an external descriptor processor, which returns an updated control word, a result kind and interrupt cause bits.

The walker writes back any control word that changed. It advances a queue's element pointer when a queued descriptor completes. At the end of the frame it reports the next frame number and the collected interrupt causes to the register file. The register file owns the frame counter and the cause register. It loads `frame_num_next` and ORs `frame_cause` into its cause register when `frame_done` pulses.

All memory traffic goes through one 32-bit read/write master with a valid/ready request and a response strobe for reads. Only one access is in flight at a time.

Top module: `sched_walker`

## Requirements
- R1: The first access of a frame is a read at `list_base + ((frame_num & 0x3FF) << 2)`.
- R2: In a link pointer, bit 0 set ends the walk, bit 1 set selects a queue head (clear selects a descriptor), bit 2 requests depth-first, and the target address is the pointer with bits [3:0] cleared. A queue head holds the horizontal link at offset 0 and the element link at offset 4. A descriptor holds link, control, token and buffer at offsets 0, 4, 8 and 12.
- R3: When a queue head's element link terminates, the walk moves to the horizontal link. When the element link selects a queue head, the walk moves to that queue head.
- R4: When a queued descriptor returns kind 0 (advance), the descriptor's link replaces the element link and is written to queue head offset 4. If the new element link has bit 2 set, the same queue is evaluated again at once; otherwise the walk moves to the horizontal link.
- R5: When a queued descriptor returns kind 1 or 3 (hold), the element link is not written, and the walk moves to the horizontal link.
- R6: The returned control word is written to descriptor offset 4 only when it differs from the word that was read.
- R7: Kind 2 (fatal) ends the frame right after any control write-back. No further descriptor is requested.
- R8: Each frame has a budget of 100 steps. One step is taken before each link is followed and one more before each queued descriptor. The frame ends when the budget would reach zero, so a descriptor that links to itself is processed 99 times.
- R9: At frame end, `frame_done` pulses for one cycle. It comes with `frame_num_next = (frame_num + 1) mod 2048`, the OR of all returned cause bits on `frame_cause`, and `frame_irq` high exactly when that OR is nonzero.
- R10: A frame tick while `run_en` is low starts no memory access and produces no `frame_done`.
- R11: A descriptor reached directly from a link (not as a queue element) is always followed by its own link, unless its result is fatal.
- R12: A memory request stays valid with a stable address until accepted. A write completes on acceptance, and a read completes on `mem_rsp_valid`. The descriptor request stays valid until `td_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | Start-of-frame pulse |
| run_en | input | 1 | Run/stop state from the command register |
| frame_num | input | 11 | Current frame number |
| list_base | input | 32 | Frame list base address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| td_req_valid | output | 1 | Descriptor handed to the processor |
| td_link | output | 32 | Descriptor link word |
| td_ctrl | output | 32 | Descriptor control word as read |
| td_token | output | 32 | Descriptor token word |
| td_buffer | output | 32 | Descriptor buffer pointer |
| td_rsp_valid | input | 1 | Processor result valid |
| td_rsp_ctrl | input | 32 | Updated control word |
| td_rsp_kind | input | 2 | 0 advance, 1/3 hold, 2 fatal |
| td_rsp_cause | input | 2 | Interrupt cause bits |
| frame_done | output | 1 | End-of-frame pulse |
| frame_num_next | output | 11 | Frame number for the next frame |
| frame_cause | output | 2 | Causes collected this frame |
| frame_irq | output | 1 | Set the interrupt status bit |

## Verification
A walker in the wrong state either follows the wrong pointer or stops in the wrong place. The damage shows up in memory: a control or element word written to the wrong address, or a write that should have happened and did not. It also shows up in the number of descriptor requests, and both are visible within the frame where the fault occurs. The bench therefore compares the entire memory image, the descriptor count, the write count and the end-of-frame outputs against a reference walk after every frame. A budget or termination error shows as a frame that ends early or late, so self-linked descriptors and linked queues are used to pin the exact step count.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int PTR_W = 32;

  typedef enum logic [1:0] {
    K_ADVANCE = 2'd0,
    K_HOLD    = 2'd1,
    K_FATAL   = 2'd2,
    K_HOLD_B  = 2'd3
  } td_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ENTRY, S_STEP, S_QH_RD, S_QH_EVAL, S_TD_RD,
    S_TD_CALL, S_WB_CTRL, S_TD_POST, S_WB_ELEM, S_DONE
  } walk_state_t;

  function automatic logic lp_term(input logic [PTR_W-1:0] p);
    return p[0];
  endfunction

  function automatic logic lp_is_qh(input logic [PTR_W-1:0] p);
    return p[1];
  endfunction

  function automatic logic lp_depth(input logic [PTR_W-1:0] p);
    return p[2];
  endfunction

  function automatic logic [PTR_W-1:0] lp_target(input logic [PTR_W-1:0] p);
    return {p[PTR_W-1:4], 4'b0000};
  endfunction
endpackage

// File: rtl/sw_mem_port.sv
module sw_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata
);
  typedef enum logic [1:0] {P_IDLE, P_REQ, P_RSP} port_state_t;
  port_state_t pst;

  always_ff @(posedge clk) begin
    if (rst) begin
      pst       <= P_IDLE;
      req_valid <= 1'b0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      case (pst)
        P_IDLE: if (start) begin
          req_valid <= 1'b1;
          req_we    <= we;
          req_addr  <= addr;
          req_wdata <= wdata;
          pst       <= P_REQ;
        end
        P_REQ: if (req_ready) begin
          req_valid <= 1'b0;
          if (req_we) begin
            done <= 1'b1;
            pst  <= P_IDLE;
          end else begin
            pst  <= P_RSP;
          end
        end
        P_RSP: if (rsp_valid) begin
          rdata <= rsp_rdata;
          done  <= 1'b1;
          pst   <= P_IDLE;
        end
        default: pst <= P_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_we)); // R12
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> pst == P_IDLE); // R12
endmodule

// File: rtl/sw_budget.sv
module sw_budget #(
  parameter int BUDGET = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(BUDGET + 1);
  localparam logic [CW-1:0] FULL = CW'(BUDGET);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= FULL;
    else if (load) cnt <= FULL;
    else if (step) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));

  AST_BUDGET_NONZERO: assert property (@(posedge clk) disable iff (rst)
    cnt != '0); // R8
  AST_STEP_ABOVE_ONE: assert property (@(posedge clk) disable iff (rst)
    step |-> cnt > CW'(1)); // R8
endmodule

// File: rtl/sched_walker.sv
module sched_walker
  import sw_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int FN_W    = 11,
  parameter int IDX_W   = 10,
  parameter int CAUSE_W = 2,
  parameter int BUDGET  = 100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_tick,
  input  logic               run_en,
  input  logic [FN_W-1:0]    frame_num,
  input  logic [AW-1:0]      list_base,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  output logic [AW-1:0]      mem_req_addr,
  output logic [DW-1:0]      mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [DW-1:0]      mem_rsp_rdata,
  output logic               td_req_valid,
  output logic [DW-1:0]      td_link,
  output logic [DW-1:0]      td_ctrl,
  output logic [DW-1:0]      td_token,
  output logic [DW-1:0]      td_buffer,
  input  logic               td_rsp_valid,
  input  logic [DW-1:0]      td_rsp_ctrl,
  input  logic [1:0]         td_rsp_kind,
  input  logic [CAUSE_W-1:0] td_rsp_cause,
  output logic               frame_done,
  output logic [FN_W-1:0]    frame_num_next,
  output logic [CAUSE_W-1:0] frame_cause,
  output logic               frame_irq
);
  localparam int TD_WORDS = 4;
  localparam int WI_W     = $clog2(TD_WORDS);
  localparam logic [AW-1:0] OFS_SECOND = AW'(DW / 8);

  walk_state_t        state;
  logic               pend;
  logic [FN_W-1:0]    fn_q;
  logic [DW-1:0]      link_q, hlink_q, elink_q, new_ctrl_q;
  logic [AW-1:0]      qh_addr, td_addr;
  logic [DW-1:0]      td_w [TD_WORDS];
  logic [WI_W-1:0]    widx;
  logic               in_queue;
  td_kind_t           kind_q;
  logic [CAUSE_W-1:0] cause_q;

  logic               mc_go, mc_we, mem_start, mem_done;
  logic [AW-1:0]      mc_addr;
  logic [DW-1:0]      mc_wdata, mem_rdata;
  logic               bud_load, bud_step, bud_last;

  // Command presented to the memory port by each access state.
  always_comb begin
    mc_go    = 1'b0;
    mc_we    = 1'b0;
    mc_addr  = '0;
    mc_wdata = '0;
    case (state)
      S_ENTRY: begin
        mc_go   = 1'b1;
        mc_addr = list_base + AW'({fn_q[IDX_W-1:0], 2'b00});
      end
      S_QH_RD: begin
        mc_go   = 1'b1;
        mc_addr = qh_addr + AW'({widx, 2'b00});
      end
      S_TD_RD: begin
        mc_go   = 1'b1;
        mc_addr = td_addr + AW'({widx, 2'b00});
      end
      S_WB_CTRL: begin
        mc_go    = 1'b1;
        mc_we    = 1'b1;
        mc_addr  = td_addr + OFS_SECOND;
        mc_wdata = new_ctrl_q;
      end
      S_WB_ELEM: begin
        mc_go    = 1'b1;
        mc_we    = 1'b1;
        mc_addr  = qh_addr + OFS_SECOND;
        mc_wdata = elink_q;
      end
      default: ;
    endcase
  end

  assign mem_start = mc_go && !pend;

  assign bud_load = (state == S_IDLE) && frame_tick && run_en;
  assign bud_step = ((state == S_STEP) && !lp_term(link_q) && !bud_last) ||
                    ((state == S_QH_EVAL) && !lp_term(elink_q) &&
                     !lp_is_qh(elink_q) && !bud_last);

  sw_mem_port #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst(rst),
    .start(mem_start), .we(mc_we), .addr(mc_addr), .wdata(mc_wdata),
    .done(mem_done), .rdata(mem_rdata),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_we(mem_req_we),
    .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
    .rsp_valid(mem_rsp_valid), .rsp_rdata(mem_rsp_rdata)
  );

  sw_budget #(.BUDGET(BUDGET)) u_budget (
    .clk(clk), .rst(rst), .load(bud_load), .step(bud_step), .last(bud_last)
  );

  assign td_link   = td_w[0];
  assign td_ctrl   = td_w[1];
  assign td_token  = td_w[2];
  assign td_buffer = td_w[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= S_IDLE;
      pend           <= 1'b0;
      fn_q           <= '0;
      link_q         <= '0;
      hlink_q        <= '0;
      elink_q        <= '0;
      new_ctrl_q     <= '0;
      qh_addr        <= '0;
      td_addr        <= '0;
      widx           <= '0;
      in_queue       <= 1'b0;
      kind_q         <= K_ADVANCE;
      cause_q        <= '0;
      td_req_valid   <= 1'b0;
      frame_done     <= 1'b0;
      frame_num_next <= '0;
      frame_cause    <= '0;
      frame_irq      <= 1'b0;
      for (int i = 0; i < TD_WORDS; i++) td_w[i] <= '0;
    end else begin
      frame_done <= 1'b0;
      if (mem_start)     pend <= 1'b1;
      else if (mem_done) pend <= 1'b0;

      case (state)
        S_IDLE: if (frame_tick && run_en) begin
          fn_q    <= frame_num;
          cause_q <= '0;
          state   <= S_ENTRY;
        end
        S_ENTRY: if (mem_done) begin
          link_q <= mem_rdata;
          state  <= S_STEP;
        end
        S_STEP: begin
          if (lp_term(link_q) || bud_last) begin
            state <= S_DONE;
          end else if (lp_is_qh(link_q)) begin
            qh_addr <= lp_target(link_q);
            widx    <= '0;
            state   <= S_QH_RD;
          end else begin
            td_addr  <= lp_target(link_q);
            in_queue <= 1'b0;
            widx     <= '0;
            state    <= S_TD_RD;
          end
        end
        S_QH_RD: if (mem_done) begin
          if (widx == '0) begin
            hlink_q <= mem_rdata;
            widx    <= widx + 1'b1;
          end else begin
            elink_q <= mem_rdata;
            state   <= S_QH_EVAL;
          end
        end
        S_QH_EVAL: begin
          if (lp_term(elink_q)) begin
            link_q <= hlink_q;
            state  <= S_STEP;
          end else if (lp_is_qh(elink_q)) begin
            link_q <= elink_q;
            state  <= S_STEP;
          end else if (bud_last) begin
            state <= S_DONE;
          end else begin
            td_addr  <= lp_target(elink_q);
            in_queue <= 1'b1;
            widx     <= '0;
            state    <= S_TD_RD;
          end
        end
        S_TD_RD: if (mem_done) begin
          td_w[widx] <= mem_rdata;
          widx       <= widx + 1'b1;
          if (widx == WI_W'(TD_WORDS - 1)) begin
            td_req_valid <= 1'b1;
            state        <= S_TD_CALL;
          end
        end
        S_TD_CALL: if (td_rsp_valid) begin
          td_req_valid <= 1'b0;
          new_ctrl_q   <= td_rsp_ctrl;
          kind_q       <= td_kind_t'(td_rsp_kind);
          cause_q      <= cause_q | td_rsp_cause;
          state        <= (td_rsp_ctrl != td_w[1]) ? S_WB_CTRL : S_TD_POST;
        end
        S_WB_CTRL: if (mem_done) state <= S_TD_POST;
        S_TD_POST: begin
          if (kind_q == K_FATAL) begin
            state <= S_DONE;
          end else if (!in_queue) begin
            link_q <= td_w[0];
            state  <= S_STEP;
          end else if (kind_q == K_ADVANCE) begin
            elink_q <= td_w[0];
            state   <= S_WB_ELEM;
          end else begin
            link_q <= hlink_q;
            state  <= S_STEP;
          end
        end
        S_WB_ELEM: if (mem_done) begin
          if (lp_depth(elink_q)) begin
            state <= S_QH_EVAL;
          end else begin
            link_q <= hlink_q;
            state  <= S_STEP;
          end
        end
        S_DONE: begin
          frame_done     <= 1'b1;
          frame_num_next <= fn_q + 1'b1;
          frame_cause    <= cause_q;
          frame_irq      <= |cause_q;
          state          <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_STOPPED_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    state == S_IDLE && !run_en |=> state == S_IDLE); // R10
  AST_TD_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    td_req_valid && !td_rsp_valid |=> td_req_valid); // R12
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R9
  AST_FATAL_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    state == S_TD_POST && kind_q == K_FATAL |=> state == S_DONE); // R7
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R2
  AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    state == S_IDLE && !pend |-> !mem_start); // R10
endmodule

// File: tb/tb_sched_walker.sv
module tb_sched_walker;
  localparam int MW = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_tick = 1'b0, run_en = 1'b0;
  logic [10:0] frame_num = '0;
  logic [31:0] list_base = '0;
  logic        mem_req_valid, mem_req_we, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        td_req_valid;
  logic [31:0] td_link, td_ctrl, td_token, td_buffer;
  logic        td_rsp_valid = 1'b0;
  logic [31:0] td_rsp_ctrl = '0;
  logic [1:0]  td_rsp_kind = '0, td_rsp_cause = '0;
  logic        frame_done, frame_irq;
  logic [10:0] frame_num_next;
  logic [1:0]  frame_cause;

  int unsigned mem [MW];
  int unsigned expm [MW];
  int n_tests = 0, n_fail = 0;
  int n_wr = 0, n_acc = 0, td_reqs = 0;
  bit rd_pend = 0, seen_rd = 0;
  logic [31:0] rd_val = '0, first_rd = '0;
  int e_tdreq, e_wr;
  logic [1:0] e_cause;

  always #10 clk = ~clk;

  sched_walker dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .run_en(run_en),
    .frame_num(frame_num), .list_base(list_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .td_req_valid(td_req_valid),
    .td_link(td_link), .td_ctrl(td_ctrl), .td_token(td_token),
    .td_buffer(td_buffer), .td_rsp_valid(td_rsp_valid),
    .td_rsp_ctrl(td_rsp_ctrl), .td_rsp_kind(td_rsp_kind),
    .td_rsp_cause(td_rsp_cause), .frame_done(frame_done),
    .frame_num_next(frame_num_next), .frame_cause(frame_cause),
    .frame_irq(frame_irq)
  );

  function automatic int widx(input logic [31:0] a);
    return int'((a >> 2) & (MW - 1));
  endfunction

  // Memory slave: random ready, random read latency.
  always @(posedge clk) begin
    if (!rst && mem_req_valid && mem_req_ready) begin
      n_acc++;
      if (mem_req_we) begin
        mem[widx(mem_req_addr)] = mem_req_wdata;
        n_wr++;
      end else begin
        rd_pend = 1;
        rd_val  = mem[widx(mem_req_addr)];
        if (!seen_rd) begin
          seen_rd  = 1;
          first_rd = mem_req_addr;
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    mem_req_ready = ($urandom % 4) != 0;
    if (rd_pend && ($urandom % 3) != 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_rdata = rd_val;
      rd_pend = 0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
  end

  // Descriptor processor: ctrl ^= token[15:8]; kind = token[1:0]; cause = token[3:2].
  initial forever begin
    @(negedge clk);
    td_rsp_valid = 1'b0;
    if (td_req_valid) begin
      repeat ($urandom % 3) @(negedge clk);
      td_rsp_ctrl  = td_ctrl ^ {24'h0, td_token[15:8]};
      td_rsp_kind  = td_token[1:0];
      td_rsp_cause = td_token[3:2];
      td_rsp_valid = 1'b1;
      td_reqs++;
      @(negedge clk);
      td_rsp_valid = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Reference model of one descriptor visit on expm.
  task automatic ref_td(input logic [31:0] a, output int kind, output logic [31:0] nxt);
    logic [31:0] c, tk, nc;
    nxt = expm[widx(a)];
    c   = expm[widx(a + 4)];
    tk  = expm[widx(a + 8)];
    nc  = c ^ {24'h0, tk[15:8]};
    if (nc != c) begin
      expm[widx(a + 4)] = nc;
      e_wr++;
    end
    kind = (tk[1:0] == 2'd3) ? 1 : int'(tk[1:0]);
    e_cause |= tk[3:2];
    e_tdreq++;
  endtask

  task automatic ref_walk(input logic [10:0] fn);
    logic [31:0] link, h, e, a, nx;
    int cnt, kind;
    bit fin, again;
    e_tdreq = 0; e_wr = 0; e_cause = '0;
    link = expm[widx(list_base + {21'h0, fn[9:0], 2'b00})];
    cnt = 100; fin = 0;
    while (!fin && !link[0]) begin
      cnt--;
      if (cnt == 0) break;
      a = {link[31:4], 4'h0};
      if (link[1]) begin
        h = expm[widx(a)];
        e = expm[widx(a + 4)];
        again = 1;
        while (again && !fin) begin
          again = 0;
          if (e[0]) link = h;
          else if (e[1]) link = e;
          else begin
            cnt--;
            if (cnt == 0) fin = 1;
            else begin
              ref_td({e[31:4], 4'h0}, kind, nx);
              if (kind == 2) fin = 1;
              else if (kind == 0) begin
                e = nx;
                expm[widx(a + 4)] = e;
                e_wr++;
                if (e[2]) again = 1; else link = h;
              end else link = h;
            end
          end
        end
      end else begin
        ref_td(a, kind, nx);
        if (kind == 2) fin = 1; else link = nx;
      end
    end
  endtask

  task automatic do_frame(input logic [10:0] fn, input string tag);
    int mism = 0;
    bit got = 0;
    expm = mem;
    ref_walk(fn);
    n_wr = 0; td_reqs = 0; seen_rd = 0;
    @(negedge clk);
    frame_num = fn; run_en = 1'b1; frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      if (frame_done) got = 1;
    end
    chk(got, {tag, " R9 frame_done"}, 32'(got), 32'h1);
    chk(first_rd == list_base + {21'h0, fn[9:0], 2'b00}, {tag, " R1 entry address"},
        first_rd, list_base + {21'h0, fn[9:0], 2'b00});
    chk(frame_num_next == fn + 11'd1, {tag, " R9 next frame"}, 32'(frame_num_next), 32'(fn + 11'd1));
    chk(frame_cause == e_cause, {tag, " R9 cause"}, 32'(frame_cause), 32'(e_cause));
    chk(frame_irq == (e_cause != 0), {tag, " R9 irq"}, 32'(frame_irq), 32'(e_cause != 0));
    chk(td_reqs == e_tdreq, {tag, " R8 descriptor count"}, 32'(td_reqs), 32'(e_tdreq));
    chk(n_wr == e_wr, {tag, " R6 write count"}, 32'(n_wr), 32'(e_wr));
    for (int i = 0; i < MW; i++) if (mem[i] != expm[i]) mism++;
    chk(mism == 0, {tag, " R4 memory image"}, 32'(mism), 32'h0);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MW; i++) mem[i] = 32'h1;
  endtask

  function automatic logic [31:0] rand_link();
    if ($urandom % 6 == 0) return 32'h1;
    return 32'h1000 + 32'(($urandom % 256) * 16) + 32'(($urandom % 2) << 1) + 32'(($urandom % 2) << 2);
  endfunction

  function automatic logic [31:0] rand_tok();
    int r = $urandom % 10;
    logic [1:0] k = (r < 6) ? 2'd0 : (r < 9) ? 2'd1 : 2'd2;
    logic [7:0] fl = ($urandom % 3 == 0) ? 8'($urandom) : 8'h0;
    return {16'($urandom), fl, 4'h0, 2'($urandom), k};
  endfunction

  initial begin
    repeat ($urandom(32'h5eed) % 1) @(posedge clk);
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req_valid && !td_req_valid && !frame_done, "R12 reset outputs idle",
        {29'h0, mem_req_valid, td_req_valid, frame_done}, 32'h0);

    // R10: stopped controller ignores the tick
    n_acc = 0;
    begin
      bit saw = 0;
      frame_tick = 1'b1; run_en = 1'b0;
      @(negedge clk); frame_tick = 1'b0;
      repeat (40) begin @(negedge clk); if (frame_done) saw = 1; end
      chk(n_acc == 0 && !saw, "R10 no walk when stopped", 32'(n_acc), 32'h0);
    end

    // R1/R2/R9: terminating entries, index masking and wrap
    do_frame(11'h405, "R2 terminate entry");
    do_frame(11'h7FF, "R9 wrap");

    // R11/R6: standalone chain, one unchanged and one changed control
    clear_mem();
    mem[0] = 32'h1000;
    mem[widx(32'h1000)] = 32'h1010; mem[widx(32'h1004)] = 32'h11; mem[widx(32'h1008)] = 32'h0000_0005;
    mem[widx(32'h1010)] = 32'h1;    mem[widx(32'h1014)] = 32'h22; mem[widx(32'h1018)] = 32'h0000_5A09;
    do_frame(11'h0, "R11 standalone chain");
    chk(td_reqs == 2, "R11 both descriptors visited", 32'(td_reqs), 32'd2);
    chk(mem[widx(32'h1014)] == 32'h78 && n_wr == 1, "R6 only changed control written",
        mem[widx(32'h1014)], 32'h78);

    // R3: element terminate -> horizontal; element QH -> that queue
    clear_mem();
    mem[1] = 32'h1102;
    mem[widx(32'h1100)] = 32'h1122; mem[widx(32'h1104)] = 32'h1;
    mem[widx(32'h1120)] = 32'h1;    mem[widx(32'h1124)] = 32'h1142;
    mem[widx(32'h1140)] = 32'h1;    mem[widx(32'h1144)] = 32'h1200;
    mem[widx(32'h1200)] = 32'h1;    mem[widx(32'h1208)] = 32'h0;
    do_frame(11'h1, "R3 queue links");
    chk(td_reqs == 1 && mem[widx(32'h1144)] == 32'h1, "R3 nested queue element advanced",
        mem[widx(32'h1144)], 32'h1);

    // R4: depth-first advances twice in one visit
    clear_mem();
    mem[2] = 32'h1302;
    mem[widx(32'h1300)] = 32'h1;    mem[widx(32'h1304)] = 32'h1400;
    mem[widx(32'h1400)] = 32'h1414; mem[widx(32'h1408)] = 32'h0;
    mem[widx(32'h1410)] = 32'h1420; mem[widx(32'h1418)] = 32'h0;
    do_frame(11'h2, "R4 depth first");
    chk(td_reqs == 2 && mem[widx(32'h1304)] == 32'h1420, "R4 element link after depth walk",
        mem[widx(32'h1304)], 32'h1420);

    // R5: hold keeps element pointer
    clear_mem();
    mem[3] = 32'h1502;
    mem[widx(32'h1500)] = 32'h1;    mem[widx(32'h1504)] = 32'h1600;
    mem[widx(32'h1600)] = 32'h1610; mem[widx(32'h1608)] = 32'h1;
    do_frame(11'h3, "R5 hold");
    chk(mem[widx(32'h1504)] == 32'h1600 && n_wr == 0, "R5 element unchanged",
        mem[widx(32'h1504)], 32'h1600);

    // R7: fatal result stops the frame
    clear_mem();
    mem[4] = 32'h1700;
    mem[widx(32'h1700)] = 32'h1710; mem[widx(32'h1708)] = 32'h0000_0106;
    mem[widx(32'h1710)] = 32'h1;    mem[widx(32'h1718)] = 32'h0;
    do_frame(11'h4, "R7 fatal");
    chk(td_reqs == 1 && frame_cause == 2'b01, "R7 nothing after fatal", 32'(td_reqs), 32'd1);

    // R8: self-linked descriptor runs out the budget
    clear_mem();
    mem[5] = 32'h1800;
    mem[widx(32'h1800)] = 32'h1800; mem[widx(32'h1808)] = 32'h0;
    do_frame(11'h5, "R8 budget self loop");
    chk(td_reqs == 99, "R8 self loop visit count", 32'(td_reqs), 32'd99);

    // R8: self-linked queue with a held element
    clear_mem();
    mem[6] = 32'h1902;
    mem[widx(32'h1900)] = 32'h1902; mem[widx(32'h1904)] = 32'h1A00;
    mem[widx(32'h1A00)] = 32'h1;    mem[widx(32'h1A08)] = 32'h1;
    do_frame(11'h6, "R8 budget queue loop");

    // Random schedules
    for (int f = 0; f < 25; f++) begin
      logic [10:0] fn = 11'($urandom);
      clear_mem();
      for (int s = 0; s < 256; s++) begin
        mem[1024 + s*4]     = rand_link();
        mem[1024 + s*4 + 1] = rand_link();
        mem[1024 + s*4 + 2] = rand_tok();
        mem[1024 + s*4 + 3] = $urandom;
      end
      mem[int'(fn[9:0])] = rand_link();
      do_frame(fn, "R4 random schedule");
    end

    run_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule